// File: doc/BRIEF.md
# Early-Select Carry-Select Adder

A combinational binary adder of parameterised width that adds two unsigned operands and a carry-in. It returns a sum word of the same width and a carry-out. The block has no clock and no reset. It can sit in any datapath where a single-cycle add is needed, for example in address computation or inside an arithmetic unit.

The adder first forms a bitwise half-sum (XOR) word and a half-carry (AND) word. Two carry chains then run side by side on these words. One chain assumes an incoming carry of zero and the other assumes an incoming carry of one. The real carry-in picks one of the two carry words before any sum bit is formed, so only one final XOR stage is needed. A bit set in the zero-assumption word is always set in the one-assumption word. Because of this ordering, the selector is a single AND-OR per bit rather than a full multiplexer.

Top module: `csel_adder`

## Requirements
- R1: When cin_i is 0 and a_i AND b_i is zero, sum_o equals a_i XOR b_i and cout_o is 0. In this case the half-sum word alone forms the result.
- R2: When cin_i is 0, {cout_o, sum_o} equals a_i + b_i. This is the output of the carry chain that assumes a carry-in of 0.
- R3: When cin_i is 1, {cout_o, sum_o} equals a_i + b_i + 1. This is the output of the carry chain that assumes a carry-in of 1.
- R4: For the same operands, cout_o with cin_i = 1 is never lower than cout_o with cin_i = 0. Inside the block, every bit set in the carry-0 word is also set in the carry-1 word.
- R5: cout_o is the carry out of bit WIDTH-1 of a_i + b_i + cin_i. This is the top bit of the selected carry word.
- R6: sum_o bit 0 equals a_i[0] XOR b_i[0] XOR cin_i.
- R7: The full-propagate corner cases give these results:
  - all-ones plus zero with cin_i = 1 gives sum_o = 0 and cout_o = 1;
  - all-ones plus all-ones with cin_i = 1 gives sum_o = all-ones and cout_o = 1;
  - zero plus zero with cin_i = 0 gives sum_o = 0 and cout_o = 0.
- R8: WIDTH is a parameter with a minimum of 2. Every legal width gives the correct sum a_i + b_i + cin_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Sum word |
| cout_o | output | 1 | Carry-out |

## Verification
The bench builds two instances of the adder. The first has WIDTH = 8 and is driven with every combination of operands and carry-in. This covers every carry chain length and every selector case, and it also allows the carry-out ordering to be compared for each operand pair. The second has WIDTH = 32 and is driven with seeded random operands and directed all-ones and zero patterns. This shows that the chain and selector scale with the parameter, including carries that ripple across the full 32 bits.

// File: rtl/csel_adder_pkg.sv
package csel_adder_pkg;
  localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/csel_half_gen.sv
module csel_half_gen #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] hsum_o,
  output logic [WIDTH-1:0] hcar_o
);
  assign hsum_o = a_i ^ b_i;
  assign hcar_o = a_i & b_i;
endmodule

// File: rtl/csel_carry_gen.sv
module csel_carry_gen #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          CIN_ONE = 1'b0
) (
  input  logic [WIDTH-1:0] hsum_i,
  input  logic [WIDTH-1:0] hcar_i,
  output logic [WIDTH-1:0] carry_o
);
  logic [WIDTH-1:0] acc;

  always_comb begin
    acc = '0;
    // fixed assumed carry-in folds into bit 0
    if (CIN_ONE) acc[0] = hcar_i[0] | hsum_i[0];
    else         acc[0] = hcar_i[0];
    for (int i = 1; i < int'(WIDTH); i++) begin
      acc[i] = (acc[i-1] & hsum_i[i]) | hcar_i[i];
    end
  end

  assign carry_o = acc;
endmodule

// File: rtl/csel_carry_sel.sv
module csel_carry_sel #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] carry0_i,
  input  logic [WIDTH-1:0] carry1_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] carry_o
);
  // carry0 implies carry1, so an AND-OR replaces the mux
  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign carry_o[i] = carry0_i[i] | (cin_i & carry1_i[i]);
  end
endmodule

// File: rtl/csel_final_sum.sv
module csel_final_sum #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] hsum_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  assign sum_o[0]         = hsum_i[0] ^ cin_i;
  assign sum_o[WIDTH-1:1] = hsum_i[WIDTH-1:1] ^ carry_i[WIDTH-2:0];
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] hsum_w;
  logic [WIDTH-1:0] hcar_w;
  logic [WIDTH-1:0] carry0_w;
  logic [WIDTH-1:0] carry1_w;
  logic [WIDTH-1:0] carry_sel_w;

  csel_half_gen #(.WIDTH(WIDTH)) half_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .hsum_o (hsum_w),
    .hcar_o (hcar_w)
  );

  csel_carry_gen #(.WIDTH(WIDTH), .CIN_ONE(1'b0)) cg0_i (
    .hsum_i  (hsum_w),
    .hcar_i  (hcar_w),
    .carry_o (carry0_w)
  );

  csel_carry_gen #(.WIDTH(WIDTH), .CIN_ONE(1'b1)) cg1_i (
    .hsum_i  (hsum_w),
    .hcar_i  (hcar_w),
    .carry_o (carry1_w)
  );

  csel_carry_sel #(.WIDTH(WIDTH)) sel_i (
    .carry0_i (carry0_w),
    .carry1_i (carry1_w),
    .cin_i    (cin_i),
    .carry_o  (carry_sel_w)
  );

  csel_final_sum #(.WIDTH(WIDTH)) fsum_i (
    .hsum_i  (hsum_w),
    .carry_i (carry_sel_w),
    .cin_i   (cin_i),
    .sum_o   (sum_o)
  );

  assign cout_o = carry_sel_w[WIDTH-1];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] carry0_w,
  input logic [WIDTH-1:0] carry1_w,
  input logic [WIDTH-1:0] carry_sel_w
);
  import csel_adder_pkg::*;

  logic [WIDTH:0] ref_w;
  assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  initial begin
    p_min_width_r8: assert (WIDTH >= MIN_WIDTH) else $error("R8 width below minimum");
  end

  always_comb begin
    p_order_r4: assert ((carry0_w & ~carry1_w) == '0) else $error("R4 carry ordering");
    p_pick_r2: assert (cin_i || carry_sel_w == carry0_w) else $error("R2 selector");
    p_pick_r3: assert (!cin_i || carry_sel_w == carry1_w) else $error("R3 selector");
    p_cout_r5: assert (cout_o == carry_sel_w[WIDTH-1]) else $error("R5 carry-out");
    p_bit0_r6: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i)) else $error("R6 bit 0");
    p_total_r8: assert ({cout_o, sum_o} == ref_w) else $error("R8 total");
  end
endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i         (a_i),
  .b_i         (b_i),
  .cin_i       (cin_i),
  .sum_o       (sum_o),
  .cout_o      (cout_o),
  .carry0_w    (carry0_w),
  .carry1_w    (carry1_w),
  .carry_sel_w (carry_sel_w)
);

// File: tb/csel_adder_tb_top.sv
`timescale 1ns/1ps
module csel_adder_tb_top;
  localparam int unsigned WN = 8;
  localparam int unsigned WW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [WN-1:0] a_n, b_n, s_n;
  logic          ci_n, co_n;
  logic [WW-1:0] a_w, b_w, s_w;
  logic          ci_w, co_w;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  csel_adder #(.WIDTH(WN)) dut_i (
    .a_i(a_n), .b_i(b_n), .cin_i(ci_n), .sum_o(s_n), .cout_o(co_n)
  );

  csel_adder #(.WIDTH(WW)) dut_w_i (
    .a_i(a_w), .b_i(b_w), .cin_i(ci_w), .sum_o(s_w), .cout_o(co_w)
  );

  function automatic logic [WW:0] add_ref(input logic [WW-1:0] a, input logic [WW-1:0] b,
                                          input logic c);
    return {1'b0, a} + {1'b0, b} + {{WW{1'b0}}, c};
  endfunction

  task automatic check(input string tag, input logic [WW:0] got, input logic [WW:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive_n(input logic [WN-1:0] a, input logic [WN-1:0] b, input logic c);
    a_n = a; b_n = b; ci_n = c;
    #4;
  endtask

  task automatic drive_w(input logic [WW-1:0] a, input logic [WW-1:0] b, input logic c);
    a_w = a; b_w = b; ci_w = c;
    #4;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [WW:0] ref_v;
    logic        co0;
    void'($urandom(32'd20240611));
    a_n = '0; b_n = '0; ci_n = 1'b0;
    a_w = '0; b_w = '0; ci_w = 1'b0;
    @(negedge clk);
    // R7 zero case
    drive_n('0, '0, 1'b0);
    check("R7 zero", {{(WW-WN){1'b0}}, co_n, s_n}, '0);
    drive_n('1, '0, 1'b1);
    check("R7 propagate", {{(WW-WN){1'b0}}, co_n, s_n}, {{(WW-WN){1'b0}}, 1'b1, {WN{1'b0}}});
    drive_n('1, '1, 1'b1);
    check("R7 ones", {{(WW-WN){1'b0}}, co_n, s_n}, {{(WW-WN){1'b0}}, 1'b1, {WN{1'b1}}});

    // exhaustive narrow instance
    for (int a = 0; a < (1 << WN); a++) begin
      for (int b = 0; b < (1 << WN); b++) begin
        co0 = 1'b0;
        for (int c = 0; c < 2; c++) begin
          drive_n(a[WN-1:0], b[WN-1:0], c[0]);
          ref_v = add_ref({{(WW-WN){1'b0}}, a[WN-1:0]}, {{(WW-WN){1'b0}}, b[WN-1:0]}, c[0]);
          check(c == 0 ? "R2" : "R3", {{(WW-WN){1'b0}}, co_n, s_n}, ref_v);
          check("R5", {{WW{1'b0}}, co_n}, {{WW{1'b0}}, ref_v[WN]});
          check("R6", {{WW{1'b0}}, s_n[0]}, {{WW{1'b0}}, a[0] ^ b[0] ^ c[0]});
          if (c == 0 && (a & b) == 0)
            check("R1", {{(WW-WN){1'b0}}, co_n, s_n},
                  {{(WW-WN){1'b0}}, 1'b0, a[WN-1:0] ^ b[WN-1:0]});
          if (c == 0) co0 = co_n;
          else check("R4", {{WW{1'b0}}, (co_n | ~co0)}, {{WW{1'b0}}, 1'b1});
          #1;
        end
      end
    end

    // wide instance: directed then random
    drive_w('1, '0, 1'b1);
    check("R7 wide propagate", {co_w, s_w}, {1'b1, {WW{1'b0}}});
    drive_w('1, '1, 1'b1);
    check("R7 wide ones", {co_w, s_w}, {1'b1, {WW{1'b1}}});
    drive_w(32'h8000_0000, 32'h8000_0000, 1'b0);
    check("R5 wide msb", {co_w, s_w}, {1'b1, {WW{1'b0}}});
    for (int k = 0; k < 3000; k++) begin
      logic [WW-1:0] ra, rb;
      logic          rc;
      ra = $urandom;
      rb = $urandom;
      rc = $urandom_range(1, 0) == 1;
      drive_w(ra, rb, rc);
      check("R8 wide random", {co_w, s_w}, add_ref(ra, rb, rc));
      #1;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule